// File: doc/BRIEF.md
# SAR Dual-Conversion Timing Sequencer

This block sequences a successive-approximation converter that digitises every input sample twice. A fixed 40-cycle frame closes the sample switch, runs a first 14-trial binary search with a positive calibration perturbation, gives the input network 6 cycles to recover, then runs a second 14-trial search with a negative perturbation. Trials go from the most significant bit down. The comparator decision at the end of each trial cycle keeps or clears the bit under trial. The 14-bit raw words carry 2 bits of redundancy for a 12-bit result. A later calibration engine compares them.

The frame state machine has five states. PH_RESET lasts 1 cycle and clears both trial registers. PH_SAMPLE lasts 5 cycles. PH_CONV1 lasts 14 cycles. PH_REGEN lasts 6 cycles. PH_CONV2 lasts 14 cycles. The transitions are: PH_RESET to PH_SAMPLE when `run` is high, otherwise PH_RESET holds; PH_SAMPLE to PH_CONV1; PH_CONV1 to PH_REGEN; PH_REGEN to PH_CONV2; PH_CONV2 to PH_RESET. Each move happens on the last cycle of the phase. A synchronous `srst` forces PH_RESET from any state.

Top module: `sar_dual_seq`

## Requirements
- R1: While `run` stays high, the phases repeat with the order and lengths PH_RESET 1, PH_SAMPLE 5, PH_CONV1 14, PH_REGEN 6 and PH_CONV2 14, so `raw_vld` pulses exactly every 40 cycles.
- R2: `smp_sw` is high in exactly the 5 cycles of PH_SAMPLE and never while a trial is active.
- R3: `trial_en` is one-hot in every conversion cycle and zero in every other cycle. Within a conversion it starts at bit 13 (value 0x2000) and moves down one bit per cycle to bit 0.
- R4: `dac_word` is zero outside conversions. During a conversion it equals the bits already decided in that conversion OR the bit under trial. `cmp_in` = 1 at the end of a trial cycle keeps that bit and 0 clears it, so the raw word is the MSB-first binary-search result.
- R5: `cal_pos` is high in exactly the 14 cycles of PH_CONV1 and `cal_neg` in exactly the 14 cycles of PH_CONV2. They are never high together.
- R6: `raw_a` (first conversion) and `raw_b` (second conversion) are updated together, and `raw_vld` is high for one cycle, in the cycle after the last trial of PH_CONV2. Both words hold their value until the next pulse.
- R7: Each conversion starts from a cleared trial register, so in its first trial cycle `dac_word` equals `trial_en`.
- R8: `run` is consulted only in PH_RESET. While it is low, the sequencer stays in PH_RESET with every control output inactive. A frame that has already started runs to completion with a valid pulse.
- R9: With `srst` high at a clock edge, the next cycle has `smp_sw`, `trial_en`, `cal_pos`, `cal_neg` and `raw_vld` low and both raw words zero. After release with `run` high, the first `raw_vld` comes 40 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single conversion clock |
| srst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the start of a new frame |
| cmp_in | input | 1 | Comparator decision for the current trial (1 keeps the bit) |
| smp_sw | output | 1 | Closes the bottom-plate sample switch |
| trial_en | output | NTRIAL | One-hot enable for the bit under trial |
| dac_word | output | NTRIAL | Capacitor-array drive word for the current trial |
| cal_pos | output | 1 | Applies the positive calibration perturbation |
| cal_neg | output | 1 | Applies the negative calibration perturbation |
| raw_a | output | NTRIAL | Raw word of the first conversion |
| raw_b | output | NTRIAL | Raw word of the second conversion |
| raw_vld | output | 1 | One-cycle strobe for both raw words |

## Verification
Some rules are checked by assertions on every cycle. These are: `trial_en` is one-hot, and it steps down one bit each cycle inside a conversion. Each decision lands in `dac_word` in the cycle after its trial. A conversion starts from a cleared word. The two perturbation enables never overlap. The sample switch never overlaps a trial. The valid strobe lasts one cycle. A reset quiets the outputs. Other behaviour shows only in the bench's scenarios. These are: the phase lengths and the 40-cycle period. The raw words match a comparator model that adds and subtracts the perturbation, including saturation at both ends of the range. The sequencer idles while `run` is low and finishes a frame already in progress. A frame aborted by `srst` restarts cleanly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        PH_RESET  = 3'd0,
        PH_SAMPLE = 3'd1,
        PH_CONV1  = 3'd2,
        PH_REGEN  = 3'd3,
        PH_CONV2  = 3'd4
    } phase_t;

    localparam int NUM_CONV = 2;

endpackage

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
    import sar_seq_pkg::*;
#(
    parameter int RST_CYC   = 1,
    parameter int SMP_CYC   = 5,
    parameter int NTRIAL    = 14,
    parameter int REGEN_CYC = 6,
    localparam int MAXA   = (RST_CYC > SMP_CYC) ? RST_CYC : SMP_CYC,
    localparam int MAXB   = (NTRIAL > REGEN_CYC) ? NTRIAL : REGEN_CYC,
    localparam int MAXLEN = (MAXA > MAXB) ? MAXA : MAXB,
    localparam int CW     = (MAXLEN > 2) ? $clog2(MAXLEN) : 1
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          run,
    output phase_t        phase,
    output logic [CW-1:0] step,
    output logic          phase_last
);

    phase_t        ph_q, ph_n;
    logic [CW-1:0] cnt_q, cnt_n;
    int            cur_len;

    // length of the phase currently running
    always_comb begin
        unique case (ph_q)
            PH_RESET:  cur_len = RST_CYC;
            PH_SAMPLE: cur_len = SMP_CYC;
            PH_CONV1:  cur_len = NTRIAL;
            PH_REGEN:  cur_len = REGEN_CYC;
            PH_CONV2:  cur_len = NTRIAL;
            default:   cur_len = RST_CYC;
        endcase
    end

    assign phase_last = (cnt_q == CW'(cur_len - 1));

    // next-state decision
    always_comb begin
        ph_n  = ph_q;
        cnt_n = cnt_q + 1'b1;
        unique case (ph_q)
            PH_RESET: begin
                if (phase_last) begin
                    if (run) begin
                        ph_n  = PH_SAMPLE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q;
                    end
                end
            end
            PH_SAMPLE: if (phase_last) begin ph_n = PH_CONV1; cnt_n = '0; end
            PH_CONV1:  if (phase_last) begin ph_n = PH_REGEN; cnt_n = '0; end
            PH_REGEN:  if (phase_last) begin ph_n = PH_CONV2; cnt_n = '0; end
            PH_CONV2:  if (phase_last) begin ph_n = PH_RESET; cnt_n = '0; end
            default: begin
                ph_n  = PH_RESET;
                cnt_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (srst) begin
            ph_q  <= PH_RESET;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_n;
            cnt_q <= cnt_n;
        end
    end

    assign phase = ph_q;
    assign step  = cnt_q;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int NTRIAL = 14
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              en,
    input  logic [NTRIAL-1:0] trial_oh,
    input  logic              cmp,
    output logic [NTRIAL-1:0] q,
    output logic [NTRIAL-1:0] q_next
);

    // the bit under trial takes the comparator decision; decided bits stay
    always_comb begin
        if (cmp) q_next = q | trial_oh;
        else     q_next = q & ~trial_oh;
    end

    always_ff @(posedge clk) begin
        if (clr)     q <= '0;
        else if (en) q <= q_next;
    end

endmodule

// File: rtl/sar_dual_seq.sv
module sar_dual_seq
    import sar_seq_pkg::*;
#(
    parameter int RST_CYC   = 1,
    parameter int SMP_CYC   = 5,
    parameter int NTRIAL    = 14,
    parameter int REGEN_CYC = 6
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              run,
    input  logic              cmp_in,
    output logic              smp_sw,
    output logic [NTRIAL-1:0] trial_en,
    output logic [NTRIAL-1:0] dac_word,
    output logic              cal_pos,
    output logic              cal_neg,
    output logic [NTRIAL-1:0] raw_a,
    output logic [NTRIAL-1:0] raw_b,
    output logic              raw_vld
);

    localparam int MAXA   = (RST_CYC > SMP_CYC) ? RST_CYC : SMP_CYC;
    localparam int MAXB   = (NTRIAL > REGEN_CYC) ? NTRIAL : REGEN_CYC;
    localparam int MAXLEN = (MAXA > MAXB) ? MAXA : MAXB;
    localparam int CW     = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;

    phase_t            phase;
    logic [CW-1:0]     step;
    logic              phase_last;
    logic [NTRIAL-1:0] trial_oh;
    logic [NTRIAL-1:0] word_q [NUM_CONV];
    logic [NTRIAL-1:0] word_n [NUM_CONV];
    logic [NTRIAL-1:0] raw_a_q, raw_b_q;
    logic              vld_q;
    logic              conv2_done;

    sar_phase_fsm #(
        .RST_CYC   (RST_CYC),
        .SMP_CYC   (SMP_CYC),
        .NTRIAL    (NTRIAL),
        .REGEN_CYC (REGEN_CYC)
    ) i_fsm (
        .clk        (clk),
        .srst       (srst),
        .run        (run),
        .phase      (phase),
        .step       (step),
        .phase_last (phase_last)
    );

    // step 0 selects the MSB, the last step the LSB
    always_comb begin
        for (int i = 0; i < NTRIAL; i++) begin
            trial_oh[i] = (step == CW'(NTRIAL - 1 - i));
        end
    end

    // one trial register per conversion, cleared in the reset phase
    generate
        for (genvar g = 0; g < NUM_CONV; g++) begin : g_conv
            localparam phase_t CONV_PH = (g == 0) ? PH_CONV1 : PH_CONV2;
            sar_trial_reg #(
                .NTRIAL (NTRIAL)
            ) i_trial (
                .clk      (clk),
                .clr      (srst || (phase == PH_RESET)),
                .en       (phase == CONV_PH),
                .trial_oh (trial_oh),
                .cmp      (cmp_in),
                .q        (word_q[g]),
                .q_next   (word_n[g])
            );
        end
    endgenerate

    assign conv2_done = (phase == PH_CONV2) && phase_last;

    // raw word capture and strobe
    always_ff @(posedge clk) begin
        if (srst) begin
            raw_a_q <= '0;
            raw_b_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= conv2_done;
            if (conv2_done) begin
                raw_a_q <= word_q[0];
                raw_b_q <= word_n[1];
            end
        end
    end

    // phase-decoded control outputs
    always_comb begin
        smp_sw   = 1'b0;
        cal_pos  = 1'b0;
        cal_neg  = 1'b0;
        trial_en = '0;
        dac_word = '0;
        unique case (phase)
            PH_SAMPLE: smp_sw = 1'b1;
            PH_CONV1: begin
                cal_pos  = 1'b1;
                trial_en = trial_oh;
                dac_word = word_q[0] | trial_oh;
            end
            PH_CONV2: begin
                cal_neg  = 1'b1;
                trial_en = trial_oh;
                dac_word = word_q[1] | trial_oh;
            end
            PH_RESET, PH_REGEN: ;
            default: ;
        endcase
    end

    assign raw_a   = raw_a_q;
    assign raw_b   = raw_b_q;
    assign raw_vld = vld_q;

endmodule

// File: rtl/sar_dual_seq_chk.sv
module sar_dual_seq_chk #(
    parameter int NTRIAL = 14
) (
    input logic              clk,
    input logic              srst,
    input logic              cmp_in,
    input logic              smp_sw,
    input logic [NTRIAL-1:0] trial_en,
    input logic [NTRIAL-1:0] dac_word,
    input logic              cal_pos,
    input logic              cal_neg,
    input logic              raw_vld
);

    assert_sample_no_trial_R2: assert property (@(posedge clk) disable iff (srst)
        smp_sw |-> (trial_en == '0 && !cal_pos && !cal_neg));

    assert_trial_onehot_R3: assert property (@(posedge clk) disable iff (srst)
        $onehot0(trial_en));

    assert_trial_in_conv_R3: assert property (@(posedge clk) disable iff (srst)
        ((trial_en != '0) == (cal_pos || cal_neg)));

    assert_trial_steps_down_R3: assert property (@(posedge clk) disable iff (srst)
        (trial_en != '0 && !trial_en[0]) |=> (trial_en == ($past(trial_en) >> 1)));

    assert_decision_kept_R4: assert property (@(posedge clk) disable iff (srst)
        (trial_en != '0 && !trial_en[0]) |=>
            (((dac_word & $past(trial_en)) != '0) == $past(cmp_in)));

    assert_idle_dac_zero_R4: assert property (@(posedge clk) disable iff (srst)
        (trial_en == '0) |-> (dac_word == '0));

    assert_cal_exclusive_R5: assert property (@(posedge clk) disable iff (srst)
        !(cal_pos && cal_neg));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (srst)
        raw_vld |=> !raw_vld);

    assert_fresh_start_R7: assert property (@(posedge clk) disable iff (srst)
        ($rose(cal_pos) || $rose(cal_neg)) |-> (dac_word == trial_en));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        srst |=> (!raw_vld && !smp_sw && trial_en == '0 && !cal_pos && !cal_neg));

endmodule

bind sar_dual_seq sar_dual_seq_chk #(.NTRIAL(NTRIAL)) i_chk (
    .clk      (clk),
    .srst     (srst),
    .cmp_in   (cmp_in),
    .smp_sw   (smp_sw),
    .trial_en (trial_en),
    .dac_word (dac_word),
    .cal_pos  (cal_pos),
    .cal_neg  (cal_neg),
    .raw_vld  (raw_vld)
);

// File: tb/test_sar_dual_seq.sv
`timescale 1ns/1ps
module test_sar_dual_seq;

    localparam int NT    = 14;
    localparam int FULL  = (1 << NT) - 1;
    localparam int DELTA = 32;
    localparam int NVEC  = 8;
    // {input level, expected first word, expected second word}
    localparam int VEC [NVEC][3] = '{
        '{    0,    32,     0},
        '{ 8192,  8224,  8160},
        '{16383, 16383, 16351},
        '{  100,   132,    68},
        '{ 5461,  5493,  5429},
        '{16360, 16383, 16328},
        '{   20,    52,     0},
        '{10923, 10955, 10891}
    };

    logic          clk = 1'b0;
    logic          srst = 1'b1;
    logic          run = 1'b0;
    logic          cmp_in;
    logic          smp_sw, cal_pos, cal_neg, raw_vld;
    logic [NT-1:0] trial_en, dac_word, raw_a, raw_b;
    int            vin = 0;
    int            checks = 0;
    int            errors = 0;

    always #2.5 clk = ~clk;

    sar_dual_seq i_sar_dual_seq (
        .clk      (clk),
        .srst     (srst),
        .run      (run),
        .cmp_in   (cmp_in),
        .smp_sw   (smp_sw),
        .trial_en (trial_en),
        .dac_word (dac_word),
        .cal_pos  (cal_pos),
        .cal_neg  (cal_neg),
        .raw_a    (raw_a),
        .raw_b    (raw_b),
        .raw_vld  (raw_vld)
    );

    // comparator model: perturbed input against a binary-weighted DAC
    always_comb begin
        int eff;
        eff = vin + (cal_pos ? DELTA : 0) - (cal_neg ? DELTA : 0);
        cmp_in = (eff >= int'(dac_word));
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // step to the next valid strobe, gathering per-frame statistics
    task automatic wait_valid(output int n, output int sm, output int cp,
                              output int cn, output int tr, output int bad);
        int pos;
        n = 0; sm = 0; cp = 0; cn = 0; tr = 0; bad = 0; pos = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (smp_sw)  sm++;
            if (cal_pos) cp++;
            if (cal_neg) cn++;
            if (trial_en != '0) begin
                tr++;
                if (pos >= NT || trial_en != NT'(1 << (NT - 1 - pos))) bad++;
                pos++;
            end else begin
                pos = 0;
            end
            if (raw_vld || n > 200) break;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, sm, cp, cn, tr, bad;
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 smp_sw", int'(smp_sw), 0);
        check("R9 trial_en", int'(trial_en), 0);
        check("R9 raw_vld", int'(raw_vld), 0);
        check("R9 raw_a", int'(raw_a), 0);
        check("R9 cal", int'(cal_pos | cal_neg), 0);

        // R8 idle with run low
        srst = 1'b0;
        sm = 0; tr = 0; n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (smp_sw) sm++;
            if (trial_en != '0) tr++;
            if (raw_vld) n++;
        end
        check("R8 idle activity", sm + tr + n, 0);

        // vector table walk
        vin = VEC[0][0];
        run = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            wait_valid(n, sm, cp, cn, tr, bad);
            check("R1 frame length", n, 40);
            check("R2 sample cycles", sm, 5);
            check("R5 cal_pos cycles", cp, 14);
            check("R5 cal_neg cycles", cn, 14);
            check("R3 trial cycles", tr, 28);
            check("R3 trial order errors", bad, 0);
            check("R4 raw_a", int'(raw_a), VEC[v][1]);
            check("R4 raw_b", int'(raw_b), VEC[v][2]);
            vin = (v + 1 < NVEC) ? VEC[v + 1][0] : 777;
        end

        // R6 strobe lasts one cycle, words hold
        @(negedge clk);
        check("R6 strobe low", int'(raw_vld), 0);
        check("R6 raw_a hold", int'(raw_a), VEC[NVEC - 1][1]);
        check("R6 raw_b hold", int'(raw_b), VEC[NVEC - 1][2]);

        // R8 run dropped mid-frame: frame completes, then idle
        run = 1'b0;
        wait_valid(n, sm, cp, cn, tr, bad);
        check("R8 frame completes", n, 39);
        check("R8 raw_a", int'(raw_a), 809);
        check("R8 raw_b", int'(raw_b), 745);
        sm = 0; tr = 0; n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (smp_sw) sm++;
            if (trial_en != '0) tr++;
            if (raw_vld) n++;
        end
        check("R8 stays idle", sm + tr + n, 0);

        // R9 abort in the first conversion
        run = 1'b1;
        repeat (12) @(negedge clk);
        check("R9 in conversion", int'(cal_pos), 1);
        srst = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 abort trial_en", int'(trial_en), 0);
        check("R9 abort cal", int'(cal_pos | cal_neg), 0);
        check("R9 abort raw_a", int'(raw_a), 0);
        check("R9 abort raw_b", int'(raw_b), 0);
        vin = 300;
        srst = 1'b0;
        wait_valid(n, sm, cp, cn, tr, bad);
        check("R9 restart length", n, 40);
        check("R7 raw_a after restart", int'(raw_a), 332);
        check("R7 raw_b after restart", int'(raw_b), 268);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule